// File: doc/BRIEF.md
# Triggered-Update Multi-Channel PWM Controller

This block generates pulse-width-modulated outputs on several independent channels. Software programs each channel through a small 32-bit register bus with address, write enable, write data and combinational read data. The programmable settings are a clock prescaler, a period length, an active-time length and an output polarity. Writes only change a staged copy of these settings. The running waveform stays untouched until software raises that channel's trigger bit. That rising edge is the only event that moves the staged values into the working set.

A per-channel smooth bit, sampled when the trigger rises, selects how the update is applied. With smooth set, the new settings wait for the end of the period that is running, so the waveform changes without a glitch. With smooth clear, they are applied after a fixed delay of DELAY_CYCLES clocks, and the period restarts from its beginning. The block has no enable bit. A channel whose trigger and smooth bits are both low drives a constant high level. A channel programmed with zero active time, or with a period shorter than two, rests at its inactive level.

The control word uses one byte lane per kind of flag, and channel n uses bit n within each lane. The output-type lane is stored and read back, but it has no effect on the waveform.

Top module: `pwm_trig_ctrl`

## Requirements
- R1: After reset, every register reads 0 and every channel output is high.
- R2: Register map. Address 0x00 is the control word, with channel n's trigger at bit n, polarity at bit 8+n, output type at bit 16+n and smooth at bit 24+n. Address 0x04 holds the prescale fields, with channel n's 3-bit value at bits 4n+2..4n. The period count of channel n is at 0x08+8n and its duty count at 0x0C+8n, each 24 bits wide. Reads return the value last written, with unimplemented bits reading 0.
- R3: Writes to prescale, period, duty or polarity leave the output unchanged until a later rising edge of that channel's trigger bit. Keeping the trigger high does not pick up new writes.
- R4: With smooth clear at the trigger's rising edge, the new settings reach the output exactly DELAY_CYCLES+1 clock cycles after the clock edge that accepts the trigger write.
- R5: With smooth set at the trigger's rising edge, the running waveform continues until its current period ends. The new settings are then applied.
- R6: While a channel's trigger and smooth bits are both 0, its output is constantly high.
- R7: A running channel's period is period_count×(prescale+1) clocks. The channel is active for the first duty_count×(prescale+1) clocks of each period.
- R8: A duty count of 0 keeps the output inactive. A duty count greater than or equal to the period count keeps it active for the whole period.
- R9: Polarity 1 drives the output high while active. Polarity 0 drives it low while active.
- R10: An applied period count of 0 or 1 holds the output at the inactive level, and the period counter stays at 0.
- R11: The channels are independent. Configuring one channel does not alter another channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | AW | Byte address of the register |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | NCH | One waveform output per channel |

## Verification
On every cycle, assertions check several internal rules. The period and prescale counters stay inside their applied limits, and a short period keeps the counter parked at zero. The working settings change only while an update is pending or delayed. A smooth trigger always leaves an update pending, and the immediate-update delay never overruns. Other behaviour shows only in the bench's scenarios. These cover the exact delay of an immediate update, the continuation of the running period under a smooth update, and the active-time ratio for each prescale, polarity and boundary count. They also cover register readback masking, the constant-high rule and channel independence, all measured at the pins over windows that span whole periods.

// File: rtl/pwm_trig_pkg.sv
package pwm_trig_pkg;
  localparam int DW  = 32;  // bus data width
  localparam int PSW = 3;   // prescale field width
  localparam int CW  = 24;  // period / duty count width

  typedef struct packed {
    logic [PSW-1:0] ps;
    logic [CW-1:0]  pc;
    logic [CW-1:0]  dc;
    logic           pol;
  } chan_cfg_t;
endpackage

// File: rtl/pwm_trig_regs.sv
module pwm_trig_regs
  import pwm_trig_pkg::*;
#(
  parameter int NCH = 6,
  parameter int AW  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         bus_addr,
  input  logic                  bus_we,
  input  logic [DW-1:0]         bus_wdata,
  output logic [DW-1:0]         bus_rdata,
  output chan_cfg_t [NCH-1:0]   shadow_o,
  output logic [NCH-1:0]        trig_o,
  output logic [NCH-1:0]        smooth_o
);
  localparam int LANE      = 8;   // control word: one byte lane per flag kind
  localparam int PS_STRIDE = 4;
  localparam int CNT_BASE  = 8;
  localparam int DUTY_BASE = 12;
  localparam int CH_STRIDE = 8;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_PSC  = AW'(4);

  function automatic logic [DW-1:0] make_ctrl_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int n = 0; n < NCH; n++)
      for (int f = 0; f < 4; f++)
        m[f*LANE+n] = 1'b1;
    return m;
  endfunction

  function automatic logic [DW-1:0] make_psc_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int n = 0; n < NCH; n++)
      m[PS_STRIDE*n +: PSW] = '1;
    return m;
  endfunction

  localparam logic [DW-1:0] CTRL_MASK = make_ctrl_mask();
  localparam logic [DW-1:0] PSC_MASK  = make_psc_mask();

  logic [DW-1:0]           ctrl_q, ctrl_d;
  logic [DW-1:0]           psc_q, psc_d;
  logic [NCH-1:0][CW-1:0]  pc_q, pc_d;
  logic [NCH-1:0][CW-1:0]  dc_q, dc_d;

  // next-state
  always_comb begin
    ctrl_d = ctrl_q;
    psc_d  = psc_q;
    pc_d   = pc_q;
    dc_d   = dc_q;
    if (bus_addr == A_CTRL) ctrl_d = bus_wdata & CTRL_MASK;
    if (bus_addr == A_PSC)  psc_d  = bus_wdata & PSC_MASK;
    for (int n = 0; n < NCH; n++) begin
      if (bus_addr == AW'(CNT_BASE + CH_STRIDE*n))  pc_d[n] = bus_wdata[CW-1:0];
      if (bus_addr == AW'(DUTY_BASE + CH_STRIDE*n)) dc_d[n] = bus_wdata[CW-1:0];
    end
  end

  // registers, enabled by the write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      psc_q  <= '0;
      pc_q   <= '0;
      dc_q   <= '0;
    end else if (bus_we) begin
      ctrl_q <= ctrl_d;
      psc_q  <= psc_d;
      pc_q   <= pc_d;
      dc_q   <= dc_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL) bus_rdata = ctrl_q;
    if (bus_addr == A_PSC)  bus_rdata = psc_q;
    for (int n = 0; n < NCH; n++) begin
      if (bus_addr == AW'(CNT_BASE + CH_STRIDE*n))  bus_rdata = DW'(pc_q[n]);
      if (bus_addr == AW'(DUTY_BASE + CH_STRIDE*n)) bus_rdata = DW'(dc_q[n]);
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_fan
    assign shadow_o[g].ps  = psc_q[PS_STRIDE*g +: PSW];
    assign shadow_o[g].pc  = pc_q[g];
    assign shadow_o[g].dc  = dc_q[g];
    assign shadow_o[g].pol = ctrl_q[LANE+g];
    assign trig_o[g]       = ctrl_q[g];
    assign smooth_o[g]     = ctrl_q[3*LANE+g];
  end

  // R2: stored words never carry bits outside the implemented fields
  assert_ctrl_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl_q & ~CTRL_MASK) == '0) && ((psc_q & ~PSC_MASK) == '0))
    else $error("control or prescale word holds unimplemented bits");
endmodule

// File: rtl/pwm_trig_chan.sv
module pwm_trig_chan
  import pwm_trig_pkg::*;
#(
  parameter int DELAY_CYCLES = 20
) (
  input  logic      clk,
  input  logic      rst_n,
  input  chan_cfg_t shadow_i,
  input  logic      trig_i,
  input  logic      smooth_i,
  output logic      pwm_o
);
  localparam int DLW = $clog2(DELAY_CYCLES + 1);

  logic            trig_q;
  chan_cfg_t       stage_q;
  chan_cfg_t       act_q, act_d;
  logic            pend_q, pend_d;
  logic            dly_busy_q, dly_busy_d;
  logic [DLW-1:0]  dly_cnt_q, dly_cnt_d;
  logic [PSW-1:0]  psc_q, psc_d;
  logic [CW-1:0]   cnt_q, cnt_d;

  logic rise, tick, run, last, boundary, load_imm, load_smooth, active;

  always_comb begin
    rise        = trig_i & ~trig_q;
    tick        = (psc_q == act_q.ps);
    run         = (act_q.pc >= CW'(2));
    last        = (cnt_q >= act_q.pc - CW'(1));
    boundary    = !run || (tick && last);
    load_imm    = dly_busy_q && (dly_cnt_q == DLW'(DELAY_CYCLES - 1));
    load_smooth = pend_q && boundary;

    act_d      = act_q;
    pend_d     = pend_q;
    dly_busy_d = dly_busy_q;
    dly_cnt_d  = dly_cnt_q;
    psc_d      = tick ? '0 : psc_q + PSW'(1);
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = last ? '0 : cnt_q + CW'(1);
    else           cnt_d = cnt_q;
    if (dly_busy_q) dly_cnt_d = dly_cnt_q + DLW'(1);

    if (rise) begin
      pend_d     = smooth_i;
      dly_busy_d = !smooth_i;
      dly_cnt_d  = '0;
    end else if (load_imm || load_smooth) begin
      act_d      = stage_q;
      pend_d     = 1'b0;
      dly_busy_d = 1'b0;
      dly_cnt_d  = '0;
      cnt_d      = '0;
      psc_d      = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q     <= 1'b0;
      act_q      <= '0;
      pend_q     <= 1'b0;
      dly_busy_q <= 1'b0;
      dly_cnt_q  <= '0;
      psc_q      <= '0;
      cnt_q      <= '0;
    end else begin
      trig_q     <= trig_i;
      act_q      <= act_d;
      pend_q     <= pend_d;
      dly_busy_q <= dly_busy_d;
      dly_cnt_q  <= dly_cnt_d;
      psc_q      <= psc_d;
      cnt_q      <= cnt_d;
    end
  end

  // staged copy captured only on a trigger rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    stage_q <= '0;
    else if (rise) stage_q <= shadow_i;
  end

  always_comb begin
    active = run && (cnt_q < act_q.dc);
    if (!trig_i && !smooth_i) pwm_o = 1'b1;
    else                      pwm_o = act_q.pol ? active : !active;
  end

  assert_cnt_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < act_q.pc))
    else $error("period counter beyond applied period");
  assert_psc_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    psc_q <= act_q.ps)
    else $error("prescale counter beyond applied prescale");
  assert_short_park_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (cnt_q == '0))
    else $error("period counter moved with a short period");
  assert_hold_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(dly_busy_q || pend_q) |=> $stable(act_q))
    else $error("working settings changed without a trigger");
  assert_smooth_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && smooth_i) |=> (pend_q && !dly_busy_q))
    else $error("smooth trigger did not leave an update pending");
  assert_delay_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dly_busy_q |-> (dly_cnt_q < DLW'(DELAY_CYCLES)))
    else $error("immediate-update delay overran");
endmodule

// File: rtl/pwm_trig_ctrl.sv
module pwm_trig_ctrl
  import pwm_trig_pkg::*;
#(
  parameter int NCH          = 6,
  parameter int AW           = 8,
  parameter int DELAY_CYCLES = 20
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  bus_addr,
  input  logic           bus_we,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic [NCH-1:0] pwm_out
);
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  chan_cfg_t [NCH-1:0] shadow;
  logic [NCH-1:0]      trig;
  logic [NCH-1:0]      smooth;

  pwm_trig_regs #(.NCH(NCH), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .shadow_o  (shadow),
    .trig_o    (trig),
    .smooth_o  (smooth)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm_trig_chan #(.DELAY_CYCLES(DELAY_CYCLES)) u_ch (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .shadow_i (shadow[g]),
      .trig_i   (trig[g]),
      .smooth_i (smooth[g]),
      .pwm_o    (pwm_out[g])
    );
  end

  // R6: idle channels (trigger and smooth both low) always drive high
  assert_idle_high_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((~trig & ~smooth & ~pwm_out) == '0))
    else $error("idle channel not driving high");
endmodule

// File: tb/sim_pwm_trig_ctrl.sv
module sim_pwm_trig_ctrl;
  localparam int CLK_PER = 10;
  localparam int NCH     = 6;
  localparam int DLY     = 4;

  logic        clk, rst_n, we;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic [NCH-1:0] pwm_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [31:0] ctrl_sh, psc_sh;

  pwm_trig_ctrl #(.NCH(NCH), .AW(8), .DELAY_CYCLES(DLY)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata), .pwm_out(pwm_out)
  );

  initial clk = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  typedef struct packed {
    logic [2:0]  ps;
    logic [23:0] pc;
    logic [23:0] dc;
    logic        pol;
    logic [15:0] win;
    logic [15:0] exp_hi;
    logic [3:0]  req;
  } vec_t;

  // window is a whole number of periods, so the high count is phase-independent
  localparam vec_t VT [8] = '{
    '{3'd0, 24'd10, 24'd3, 1'b1, 16'd100, 16'd30, 4'd7},  // R7 basic ratio
    '{3'd0, 24'd10, 24'd3, 1'b0, 16'd100, 16'd70, 4'd9},  // R9 inverted
    '{3'd0, 24'd5,  24'd9, 1'b1, 16'd50,  16'd50, 4'd8},  // R8 duty >= period
    '{3'd0, 24'd8,  24'd0, 1'b1, 16'd80,  16'd0,  4'd8},  // R8 zero duty
    '{3'd3, 24'd5,  24'd2, 1'b1, 16'd100, 16'd40, 4'd7},  // R7 prescale 3
    '{3'd7, 24'd3,  24'd1, 1'b1, 16'd96,  16'd32, 4'd7},  // R7 prescale 7
    '{3'd0, 24'd1,  24'd1, 1'b1, 16'd40,  16'd0,  4'd10}, // R10 period 1
    '{3'd0, 24'd0,  24'd5, 1'b0, 16'd40,  16'd40, 4'd10}  // R10 period 0, inverted
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b0;
    #1 d = rdata;
  endtask

  task automatic set_ctrl(input int ch, input logic tr, input logic sm, input logic pol);
    ctrl_sh[ch]    = tr;
    ctrl_sh[8+ch]  = pol;
    ctrl_sh[24+ch] = sm;
    wr(8'h00, ctrl_sh);
  endtask

  task automatic apply(input int ch, input logic [2:0] ps, input logic [23:0] pc,
                       input logic [23:0] dc, input logic pol, input logic sm);
    set_ctrl(ch, 1'b0, 1'b1, pol);
    psc_sh[4*ch +: 3] = ps;
    wr(8'h04, psc_sh);
    wr(8'(8 + 8*ch), {8'h0, pc});
    wr(8'(12 + 8*ch), {8'h0, dc});
    set_ctrl(ch, 1'b1, sm, pol);
  endtask

  task automatic count_high(input int ch, input int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      c += int'(pwm_out[ch]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1..: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int c;
    logic prev;
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    ctrl_sh = '0; psc_sh = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 outputs after reset", 32'(pwm_out), 32'h3F);
    rd(8'h00, r); chk("R1 ctrl reads 0", r, 0);
    rd(8'h08, r); chk("R1 period ch0 reads 0", r, 0);
    rd(8'h34, r); chk("R1 duty ch5 reads 0", r, 0);

    // R2 readback and masking
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, r); chk("R2 period ch1 24-bit", r, 32'h00FF_FFFF);
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, r); chk("R2 prescale fields", r, 32'h0077_7777);
    wr(8'h00, 32'hFFFF_FF00); rd(8'h00, r); chk("R2 ctrl mask", r, 32'h3F3F_3F00);
    wr(8'h00, 32'h0); wr(8'h04, 32'h0); wr(8'h10, 32'h0);
    chk("R6 outputs high with ctrl clear", 32'(pwm_out), 32'h3F);

    // table of configurations on channel 2, immediate update
    for (int i = 0; i < 8; i++) begin
      apply(2, VT[i].ps, VT[i].pc, VT[i].dc, VT[i].pol, 1'b0);
      repeat (DLY + 4) @(negedge clk);
      count_high(2, int'(VT[i].win), c);
      total++;
      if (c != int'(VT[i].exp_hi)) begin
        bad++;
        $display("FAIL R%0d vector %0d actual=%0d expected=%0d", VT[i].req, i, c, VT[i].exp_hi);
      end
      chk("R11 ch0 untouched", 32'(pwm_out[0]), 1);
    end

    // R3 trigger held high: new shadow writes ignored
    apply(2, 3'd0, 24'd10, 24'd0, 1'b1, 1'b0);
    repeat (DLY + 4) @(negedge clk);
    wr(8'h1C, 32'd10);
    count_high(2, 50, c); chk("R3 held trigger ignores write", c, 0);
    rd(8'h1C, r); chk("R3 shadow duty readback", r, 10);

    // R4 immediate-update delay
    apply(2, 3'd0, 24'd10, 24'd10, 1'b1, 1'b0);
    repeat (DLY + 4) @(negedge clk);
    set_ctrl(2, 1'b0, 1'b1, 1'b1);
    wr(8'h1C, 32'd0);
    count_high(2, 30, c); chk("R3 staged write not applied", c, 30);
    set_ctrl(2, 1'b1, 1'b0, 1'b1);
    c = 0;
    while (pwm_out[2] == 1'b1 && c < 100) begin
      c++;
      @(negedge clk);
    end
    chk("R4 immediate delay", c, DLY + 1);

    // R5 smooth update waits for the period end
    apply(2, 3'd0, 24'd200, 24'd100, 1'b1, 1'b0);
    repeat (DLY + 4) @(negedge clk);
    set_ctrl(2, 1'b0, 1'b1, 1'b1);
    wr(8'h1C, 32'd0);
    prev = pwm_out[2];
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (!prev && pwm_out[2]) break;
      prev = pwm_out[2];
    end
    set_ctrl(2, 1'b1, 1'b1, 1'b1);
    repeat (50) @(negedge clk);
    chk("R5 old waveform continues", 32'(pwm_out[2]), 1);
    repeat (200) @(negedge clk);
    chk("R5 new settings after boundary", 32'(pwm_out[2]), 0);
    count_high(2, 100, c); chk("R5 stays at new settings", c, 0);

    // R6 both bits low forces high
    set_ctrl(2, 1'b0, 1'b0, 1'b1);
    chk("R6 forced high at once", 32'(pwm_out[2]), 1);
    count_high(2, 20, c); chk("R6 forced high held", c, 20);

    // R11 another channel runs while channel 2 idles
    apply(3, 3'd0, 24'd4, 24'd1, 1'b1, 1'b0);
    repeat (DLY + 4) @(negedge clk);
    count_high(3, 40, c); chk("R11 ch3 waveform", c, 10);
    count_high(2, 40, c); chk("R11 ch2 unaffected", c, 40);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule